// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Access Sequencer

This block sits between a simple on-chip request port and an asynchronous fast-page-mode DRAM of 256 rows, 256 columns and 16-bit words. A 16-bit word address is split into a row half and a column half. Both halves go out over one shared set of address pins. The block generates the active-low row strobe, two column strobes (one per byte lane), write enable and output enable. It also controls the direction of the data bus. Every analog timing limit is given as a whole number of system-clock cycles through parameters, and the sequencer counts those cycles.

After an access the row is left open. A later request to the same row skips activation and cycles only the column strobes. A request to a different row, a pending refresh, or a row that has been open too long closes the row and waits out precharge. Refresh is done by an outside scheduler. It raises a request, waits for the grant, and signals completion. While the grant is held, all strobes from this block stay inactive.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The request address bits [15:8] appear on `dram_addr` when `dram_ras_n` falls, and bits [7:0] appear on `dram_addr` when a column strobe falls. A word written to an address is read back unchanged from that address.
- R2: In a write, `req_be[0]` = 1 lowers `dram_casl_n` and writes data bits [7:0], and `req_be[1]` = 1 lowers `dram_cash_n` and writes bits [15:8]. A lane whose enable is 0 keeps its strobe high, so its byte is preserved. A read lowers both strobes.
- R3: Each accepted read produces exactly one `rsp_valid` pulse, in request order. The data is sampled when the column strobes rise. The column strobes stay low for at least `T_CAS` cycles, and the row strobe has been low for at least `T_RAC` cycles at capture.
- R4: A column strobe never falls sooner than `T_RCD` cycles after `dram_ras_n` fell.
- R5: Once `dram_ras_n` rises, it stays high for at least `T_RP` cycles before falling again.
- R6: Accesses to the currently open row are served without raising `dram_ras_n`. Between two column accesses, both column strobes stay high for at least `T_CP` cycles.
- R7: `dram_ras_n` never stays low for more than `RAS_MAX` cycles. An idle open row is closed on its own.
- R8: Whenever a column strobe is low with `dram_we_n` low, the host drives the data bus (`dram_dq_oe` = 1) and `dram_oe_n` is high.
- R9: `dram_dq_oe` and a low `dram_oe_n` are never asserted together.
- R10: A refresh request closes any open row, waits out precharge, and then raises `ref_gnt`. While `ref_gnt` is high, all three strobes are high and `req_ready` is 0. `ref_done` ends the grant.
- R11: A request to a row other than the open one closes the row, precharges, and activates the new row. Each such miss costs one extra row activation.
- R12: After reset, all strobes, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe`, `rsp_valid` and `ref_gnt` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address, row in [15:8], column in [7:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables for writes |
| req_ready | output | 1 | Request accepted on this clock when valid |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh wanted by the scheduler |
| ref_gnt | output | 1 | DRAM handed to the refresh scheduler |
| ref_done | input | 1 | Refresh finished, grant may end |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Host drives the data bus |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The bench puts the sequencer in front of a behavioural DRAM model. That model latches the row and column on the strobe edges and honours each byte strobe separately, so a wrong address split or wrong lane shows up as bad read data. The main function is driven by several patterns. Long same-row runs show whether only the column strobes toggle. Alternating rows that share a column show whether the row half is really used and whether every miss activates again. Single-lane writes over a full word show lane isolation. A pseudo-random mix of reads, writes and lanes over a few rows tests ordering under both hits and misses. Idle periods and refresh requests made with a row open exercise the automatic close, precharge spacing and the strobe-idle grant.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_CAS   = 2,
  parameter int T_CP    = 1,
  parameter int T_RAC   = 2,
  parameter int RAS_MAX = 500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [1:0]          req_be,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic                ref_req,
  output logic                ref_gnt,
  input  logic                ref_done,
  output logic [ADDR_W-1:0]   dram_addr,
  output logic                dram_ras_n,
  output logic                dram_casl_n,
  output logic                dram_cash_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);
  localparam int CW       = $clog2(RAS_MAX + 2);
  localparam int PAGE_LIM = RAS_MAX - T_CAS - 1;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_CAS, S_OPEN, S_PRE, S_REF} state_t;

  state_t            st;
  logic [CW-1:0]     cnt, ras_age, cp_cnt;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              wr_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wd_q;

  logic [ADDR_W-1:0] req_row, req_col, c_col;
  logic              c_wr, page_hit, close_row, launch;
  logic [1:0]        c_be;
  logic [DATA_W-1:0] c_wd;

  assign req_row  = req_addr[2*ADDR_W-1:ADDR_W];
  assign req_col  = req_addr[ADDR_W-1:0];
  assign page_hit = (req_row == row_q);

  assign c_col = (st == S_OPEN) ? req_col   : col_q;
  assign c_wr  = (st == S_OPEN) ? req_write : wr_q;
  assign c_be  = (st == S_OPEN) ? req_be    : be_q;
  assign c_wd  = (st == S_OPEN) ? req_wdata : wd_q;

  assign req_ready = !ref_req &&
                     ((st == S_IDLE) ||
                      (st == S_OPEN && page_hit && cp_cnt == '0 &&
                       ras_age < CW'(PAGE_LIM)));

  assign close_row = (st == S_OPEN) &&
                     (ref_req || (req_valid && !page_hit) || ras_age >= CW'(PAGE_LIM));

  assign launch = (st == S_ACT && cnt == '0) ||
                  (st == S_OPEN && !close_row && req_valid && req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      ras_age     <= '0;
      cp_cnt      <= '0;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      be_q        <= '0;
      wd_q        <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      ref_gnt     <= 1'b0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_casl_n <= 1'b1;
      dram_cash_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (cp_cnt != '0) cp_cnt <= cp_cnt - 1'b1;
      if (!dram_ras_n && ras_age != '1) ras_age <= ras_age + 1'b1;

      case (st)
        S_IDLE: begin
          if (ref_req) begin
            ref_gnt <= 1'b1;
            st      <= S_REF;
          end else if (req_valid) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= req_row;
            row_q      <= req_row;
            col_q      <= req_col;
            wr_q       <= req_write;
            be_q       <= req_be;
            wd_q       <= req_wdata;
            ras_age    <= CW'(1);
            cnt        <= CW'(T_RCD - 1);
            st         <= S_ACT;
          end
        end
        S_ACT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end
        S_CAS: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (wr_q || ras_age >= CW'(T_RAC)) begin
            dram_casl_n <= 1'b1;
            dram_cash_n <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_dq_oe  <= 1'b0;
            if (!wr_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
            cp_cnt <= CW'(T_CP - 1);
            st     <= S_OPEN;
          end
        end
        S_OPEN: begin
          if (close_row) begin
            dram_ras_n <= 1'b1;
            cnt        <= CW'(T_RP - 1);
            st         <= S_PRE;
          end
        end
        S_PRE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           st  <= S_IDLE;
        end
        S_REF: begin
          if (ref_done) begin
            ref_gnt <= 1'b0;
            cnt     <= CW'(T_RP - 1);
            st      <= S_PRE;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (launch) begin
        dram_addr   <= c_col;
        dram_casl_n <= c_wr ? !c_be[0] : 1'b0;
        dram_cash_n <= c_wr ? !c_be[1] : 1'b0;
        dram_we_n   <= !c_wr;
        dram_oe_n   <= c_wr;
        dram_dq_oe  <= c_wr;
        dram_dq_out <= c_wd;
        wr_q        <= c_wr;
        cnt         <= CW'(T_CAS - 1);
        st          <= S_CAS;
      end
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_CP    = 1,
  parameter int RAS_MAX = 500
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic casl_n,
  input logic cash_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic gnt
);
  logic        cas_any;
  logic [15:0] low_c, high_c, cashi_c;

  assign cas_any = !casl_n || !cash_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_c   <= '0;
      high_c  <= 16'(T_RP);
      cashi_c <= 16'(T_CP);
    end else begin
      if (ras_n)               low_c <= '0;
      else if (low_c != '1)    low_c <= low_c + 1'b1;
      if (!ras_n)              high_c <= '0;
      else if (high_c != '1)   high_c <= high_c + 1'b1;
      if (cas_any)             cashi_c <= '0;
      else if (cashi_c != '1)  cashi_c <= cashi_c + 1'b1;
    end
  end

  p_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_any) && !ras_n |-> low_c >= 16'(T_RCD));

  p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> high_c >= 16'(T_RP));

  p_cas_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_any) |-> cashi_c >= 16'(T_CP));

  p_ras_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> low_c < 16'(RAS_MAX));

  p_early_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cas_any && !we_n |-> dq_oe && oe_n);

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  p_grant_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> ras_n && casl_n && cash_n);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_CP(T_CP), .RAS_MAX(RAS_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .casl_n(dram_casl_n),
  .cash_n(dram_cash_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
  .dq_oe(dram_dq_oe), .gnt(ref_gnt)
);

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;
  localparam int T_RCD = 2, T_RP = 2, T_CAS = 2, T_CP = 1, T_RAC = 5, RAS_MAX = 40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        ref_req = 1'b0, ref_gnt, ref_done = 1'b0;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out, dram_dq_in;

  always #10 clk = ~clk;

  fpm_dram_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP), .T_CAS(T_CAS), .T_CP(T_CP),
                  .T_RAC(T_RAC), .RAS_MAX(RAS_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .ref_done(ref_done),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n),
    .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  // behavioural DRAM
  logic [15:0] cells [int];
  logic [7:0]  m_row;
  logic [15:0] rd_word = 16'hDEAD;
  always @(negedge dram_ras_n) m_row = dram_addr;
  always @(negedge dram_casl_n or negedge dram_cash_n) begin
    int k;
    logic [15:0] v;
    k = {m_row, dram_addr};
    v = cells.exists(k) ? cells[k] : 16'h0000;
    if (!dram_we_n) begin
      if (!dram_casl_n) v[7:0]  = dram_dq_out[7:0];
      if (!dram_cash_n) v[15:8] = dram_dq_out[15:8];
      cells[k] = v;
    end else begin
      rd_word = v;
    end
  end
  assign dram_dq_in = (!dram_oe_n && !(dram_casl_n && dram_cash_n)) ? rd_word : 16'hDEAD;

  // bookkeeping
  int n_checks = 0, n_errors = 0, ras_falls = 0;
  logic [15:0] ref_mem [int];
  logic [15:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // driver
  task automatic send(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (wr) begin
      logic [15:0] v;
      v = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
      if (be[0]) v[7:0]  = d[7:0];
      if (be[1]) v[15:8] = d[15:8];
      ref_mem[a] = v;
    end else begin
      exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 16'h0000);
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R3 outstanding reads", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R1/R2/R3 read data", rsp_rdata, e);
      end
    end
  end

  // strobe timing monitor
  int  hi_cnt = 100, low_cnt = 0, cas_hi = 100;
  bit  prev_ras = 1'b1, prev_cas = 1'b0, prev_gnt = 1'b0;
  always @(negedge clk) begin
    bit cas_any;
    cas_any = !dram_casl_n || !dram_cash_n;
    if (rst_n) begin
      if (dram_ras_n) begin
        if (!prev_ras) chk(low_cnt <= RAS_MAX, "R7 row strobe low width", low_cnt, RAS_MAX);
        hi_cnt++; low_cnt = 0;
      end else begin
        if (prev_ras) begin
          chk(hi_cnt >= T_RP, "R5 precharge", hi_cnt, T_RP);
          hi_cnt = 0; ras_falls++;
        end
        low_cnt++;
      end
      if (cas_any && !prev_cas) begin
        chk(!dram_ras_n && low_cnt >= T_RCD + 1, "R4 row-to-column delay", low_cnt, T_RCD + 1);
        chk(cas_hi >= T_CP, "R6 column precharge", cas_hi, T_CP);
        if (!dram_we_n) chk(dram_dq_oe && dram_oe_n, "R8 early write bus", {dram_dq_oe, dram_oe_n}, 3);
        else            chk(!dram_dq_oe && !dram_oe_n, "R9 read bus release", {dram_dq_oe, dram_oe_n}, 0);
        cas_hi = 0;
      end else if (!cas_any) cas_hi++;
      if (ref_gnt && !prev_gnt) begin
        chk(dram_ras_n && dram_casl_n && dram_cash_n, "R10 strobes idle at grant",
            {dram_ras_n, dram_casl_n, dram_cash_n}, 7);
        chk(hi_cnt >= T_RP, "R10 precharge before grant", hi_cnt, T_RP);
      end
      prev_ras = dram_ras_n; prev_cas = cas_any; prev_gnt = ref_gnt;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic do_refresh();
    int w;
    @(negedge clk);
    ref_req = 1'b1;
    w = 0;
    while (!ref_gnt && w < 100) begin @(negedge clk); w++; end
    chk(ref_gnt, "R10 grant given", ref_gnt, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h3001; req_be = 2'b11; req_wdata = 16'hBAD0;
    repeat (3) begin
      #1 chk(!req_ready && dram_ras_n, "R10 no access during grant", {req_ready, dram_ras_n}, 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    ref_done = 1'b1; ref_req = 1'b0;
    @(negedge clk);
    ref_done = 1'b0;
    #1 chk(!ref_gnt, "R10 grant released", ref_gnt, 0);
  endtask

  initial begin
    int f0;
    logic [15:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk(dram_ras_n && dram_casl_n && dram_cash_n && dram_we_n && dram_oe_n,
        "R12 strobes idle", {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!dram_dq_oe && !rsp_valid && !ref_gnt, "R12 flags clear", {dram_dq_oe, rsp_valid, ref_gnt}, 0);
    chk(req_ready, "R12 ready after reset", req_ready, 1);

    // R1 basic word write / read
    send(1, 16'h0503, 16'h1234, 2'b11);
    send(0, 16'h0503, 16'h0, 2'b00);
    // R2 byte lanes
    send(1, 16'h0510, 16'hAAAA, 2'b11);
    send(1, 16'h0510, 16'h0055, 2'b01);
    send(0, 16'h0510, 16'h0, 2'b00);
    send(1, 16'h0510, 16'h33FF, 2'b10);
    send(0, 16'h0510, 16'h0, 2'b00);
    drain();
    chk(cells.exists(16'h0510) && cells[16'h0510] == 16'h3355, "R2 lane isolation in array",
        cells.exists(16'h0510) ? cells[16'h0510] : 0, 16'h3355);

    // R6 page hits: one activation for a run in row 07
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) send(1, 16'h0700 + 16'(i), 16'hC000 + 16'(i), 2'b11);
    for (int i = 0; i < 4; i++) send(0, 16'h0700 + 16'(i), 16'h0, 2'b00);
    drain();
    chk(ras_falls == f0 + 1, "R6 same-row run single activation", ras_falls - f0, 1);

    // R11 / R1 page misses with shared column
    f0 = ras_falls;
    send(1, 16'h10AA, 16'h1111, 2'b11);
    send(1, 16'h20AA, 16'h2222, 2'b11);
    send(0, 16'h10AA, 16'h0, 2'b00);
    send(0, 16'h20AA, 16'h0, 2'b00);
    drain();
    chk(ras_falls == f0 + 4, "R11 activation per row change", ras_falls - f0, 4);

    // R7 idle row auto-close
    repeat (RAS_MAX + 20) @(negedge clk);
    #1 chk(dram_ras_n, "R7 idle row closed", dram_ras_n, 1);

    // R10 refresh with a row open, then from idle
    send(1, 16'h3001, 16'h5A5A, 2'b11);
    repeat (2) @(negedge clk);
    #1 chk(!dram_ras_n, "R10 row open before refresh", dram_ras_n, 0);
    do_refresh();
    send(0, 16'h3001, 16'h0, 2'b00);
    drain();
    repeat (RAS_MAX + 5) @(negedge clk);
    do_refresh();
    send(0, 16'h0503, 16'h0, 2'b00);
    drain();

    // mixed pattern over four rows
    lfsr = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      logic [15:0] a;
      logic [1:0]  be;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a  = {6'b010000, lfsr[1:0], 5'b0, lfsr[4:2]};
      be = (lfsr[6:5] == 2'b00) ? 2'b11 : lfsr[6:5];
      send(lfsr[8], a, lfsr ^ 16'h9E37, be);
    end
    drain();
    finish_run();
  end
endmodule